// File: doc/BRIEF.md
# Serial-Loaded Octal Trim Code Register Bank

This block is the digital front end of an eight-channel, 8-bit trim converter. A three-wire serial port (active-low select `sel_n`, serial clock `sclk`, serial data `sdata`) delivers 11-bit words. Each word carries a 3-bit channel address followed by an 8-bit code. When the select line is released, the code is stored in one of eight code latches. The latch outputs feed the analog ladders, which are outside this block. A per-channel enable flag tells the analog stage whether to power up.

The serial pins are sampled by the block's own clock `clk` through a two-stage synchronizer. An edge detector then finds each rising `sclk` edge. A framing state machine has three states:

- **FS_IDLE**: waits for select.
- **FS_SHIFT**: collects bits, with a bit counter that saturates at eleven.
- **FS_COMMIT**: issues a one-cycle write.

Its transitions are:

- FS_IDLE→FS_SHIFT when select goes low.
- FS_SHIFT→FS_SHIFT on each sampled bit.
- FS_SHIFT→FS_COMMIT when select rises after at least eleven bits.
- FS_SHIFT→FS_IDLE when select rises after fewer bits.
- FS_COMMIT→FS_IDLE unconditionally.
- Any state→FS_IDLE while the preset input is low.

An asynchronous, active-low preset `preset_n` loads every latch with midscale. A `shutdown` input turns off the channel enables but leaves the stored codes untouched.

Top module: `octal_trim_regs`

## Requirements
- R1: A word is 11 bits, shifted in most significant bit first. The first three bits form the address, with the first bit as address MSB. The remaining eight bits form the code, with the fourth bit of the word as code bit 7. Each `sclk` level must be held for at least 2 `clk` cycles, and a bit is taken on each rising `sclk` edge while `sel_n` is low.
- R2: Address value a (0..7) selects channel a+1. Its code is driven on `chan_code[8*a+7 : 8*a]`.
- R3: A write changes only the addressed latch. Channels may be written in any order.
- R4: No latch changes while `sel_n` is low. A valid word takes effect within four `clk` rising edges after `sel_n` rises.
- R5: A frame with fewer than 11 bits is discarded and leaves all latches unchanged.
- R6: A frame with more than 11 bits writes using only the last 11 bits received.
- R7: While `preset_n` is low, every latch reads 0x80, with no clock needed. A frame in progress when the preset arrives is abandoned.
- R8: While `shutdown` is high, `chan_on` is 8'h00. Otherwise it is 8'hFF. Entering or leaving shutdown does not alter any code.
- R9: Frames received during shutdown still update the latches, and the new codes are in force when shutdown is released.
- R10: `sclk` edges while `sel_n` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial pins |
| preset_n | input | 1 | Asynchronous active-low midscale preset and state reset |
| sel_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial bit clock |
| sdata | input | 1 | Serial data, address then code, MSB first |
| shutdown | input | 1 | High turns all channel enables off |
| chan_code | output | 64 | Eight 8-bit codes, channel 1 in the lowest byte |
| chan_on | output | 8 | Per-channel analog enable |

## Verification
Several properties are checked on every clock:

- A commit only follows a released select with a full bit count.
- The commit lasts exactly one cycle.
- At most one latch is hit per write, and each unaddressed latch stays stable.
- An addressed latch takes the word's code.
- Codes are stable across shutdown when nothing is written.
- A held preset leaves every latch at midscale.

Other behaviours depend on the order of serial stimulus, so only the bench scenarios can show them:

- Bit ordering and address mapping.
- Discarding of short frames.
- Use of the trailing eleven bits of a long frame.
- Abandonment of a frame cut by the preset.
- Blindness to `sclk` outside the select window.
- Writes that land during shutdown.

The bench's reference model is compared against every channel on every clock.

// File: rtl/otr_pkg.sv
package otr_pkg;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_SHIFT  = 2'd1,
        FS_COMMIT = 2'd2
    } frame_state_e;

endpackage

// File: rtl/otr_sync.sv
module otr_sync #(
    parameter int            WIDTH   = 3,
    parameter int            STAGES  = 2,
    parameter logic [2:0]    RST_VAL = 3'b001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q[0] <= RST_VAL[WIDTH-1:0];
        end else begin
            pipe_q[0] <= din;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q[s] <= RST_VAL[WIDTH-1:0];
            end else begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/otr_frame.sv
module otr_frame
    import otr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sclk_s,
    input  logic              sdata_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CODE_W-1:0] wr_data
);

    localparam int WORD_W = ADDR_W + CODE_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    frame_state_e      state_q, state_d;
    logic              sclk_q;
    logic              sclk_rise;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    assign sclk_rise = sclk_s & ~sclk_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift register, bit counter and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (state_q == FS_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == FS_SHIFT && sclk_rise && !sel_n_s) begin
                shreg_q <= {shreg_q[WORD_W-2:0], sdata_s};
                if (cnt_q != FULL_CNT) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        unique case (state_q)
            FS_IDLE: begin
                if (!sel_n_s) begin
                    state_d = FS_SHIFT;
                end
            end
            FS_SHIFT: begin
                if (sel_n_s) begin
                    state_d = (cnt_q == FULL_CNT) ? FS_COMMIT : FS_IDLE;
                end
            end
            FS_COMMIT: begin
                wr_en   = 1'b1;
                state_d = FS_IDLE;
            end
            default: begin
                state_d = FS_IDLE;
            end
        endcase
    end

    assign wr_addr = shreg_q[WORD_W-1 -: ADDR_W];
    assign wr_data = shreg_q[CODE_W-1:0];

    // R5 R6
    commit_full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_COMMIT) |-> (cnt_q == FULL_CNT));

    // R4
    commit_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_COMMIT) |-> $past(sel_n_s));

    // R1
    commit_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_COMMIT) |=> (state_q == FS_IDLE));

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

endmodule

// File: rtl/otr_latches.sv
module otr_latches #(
    parameter int CH_N   = 8,
    parameter int ADDR_W = 3,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CODE_W-1:0]        wr_data,
    output logic [CH_N*CODE_W-1:0]   codes
);

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic [CH_N-1:0]   hit;
    logic [CODE_W-1:0] code_q [CH_N];

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        assign hit[i] = wr_en && (wr_addr == ADDR_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[i] <= MID_CODE;
            end else if (hit[i]) begin
                code_q[i] <= wr_data;
            end
        end

        assign codes[i*CODE_W +: CODE_W] = code_q[i];

        // R3
        untouched_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[i] |=> $stable(codes[i*CODE_W +: CODE_W]));

        // R2
        hit_loads_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> (codes[i*CODE_W +: CODE_W] == $past(wr_data)));
    end

    // R3
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/octal_trim_regs.sv
module octal_trim_regs #(
    parameter int CH_N      = 8,
    parameter int CODE_W    = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic                    clk,
    input  logic                    preset_n,
    input  logic                    sel_n,
    input  logic                    sclk,
    input  logic                    sdata,
    input  logic                    shutdown,
    output logic [CH_N*CODE_W-1:0]  chan_code,
    output logic [CH_N-1:0]         chan_on
);

    localparam int ADDR_W = $clog2(CH_N);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic [2:0]        pins_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [CODE_W-1:0] wr_data;

    otr_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STG),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst_n(preset_n),
        .din  ({sdata, sclk, sel_n}),
        .dout (pins_s)
    );

    otr_frame #(
        .ADDR_W(ADDR_W),
        .CODE_W(CODE_W)
    ) u_frame (
        .clk    (clk),
        .rst_n  (preset_n),
        .sel_n_s(pins_s[0]),
        .sclk_s (pins_s[1]),
        .sdata_s(pins_s[2]),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    otr_latches #(
        .CH_N  (CH_N),
        .ADDR_W(ADDR_W),
        .CODE_W(CODE_W)
    ) u_latches (
        .clk    (clk),
        .rst_n  (preset_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .codes  (chan_code)
    );

    assign chan_on = {CH_N{~shutdown}};

    // R8
    shutdown_hold_chk: assert property (@(posedge clk) disable iff (!preset_n)
        (shutdown && !wr_en) |=> $stable(chan_code));

    // R7
    preset_mid_chk: assert property (@(posedge clk)
        !preset_n |=> (!preset_n -> (chan_code == {CH_N{MID_CODE}})));

endmodule

// File: tb/octal_trim_regs_test.sv
module octal_trim_regs_test;

    logic        clk = 1'b0;
    logic        preset_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic        shutdown = 1'b0;
    logic [63:0] chan_code;
    logic [7:0]  chan_on;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    int    hold_cnt = 0;
    int    exp_code [8];
    string cur_req = "R7";
    bit    fq [$];

    always #2 clk = ~clk;

    octal_trim_regs uut (
        .clk      (clk),
        .preset_n (preset_n),
        .sel_n    (sel_n),
        .sclk     (sclk),
        .sdata    (sdata),
        .shutdown (shutdown),
        .chan_code(chan_code),
        .chan_on  (chan_on)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        for (int i = 0; i < 8; i++) chk(int'(chan_code[i*8 +: 8]), exp_code[i], tag);
    endtask

    // Reference comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (hold_cnt > 0) begin
            hold_cnt--;
        end else if (preset_n) begin
            for (int i = 0; i < 8; i++) begin
                checks++;
                if (int'(chan_code[i*8 +: 8]) != exp_code[i]) begin
                    failures++;
                    $display("FAIL %s ch%0d actual=%0h expected=%0h", cur_req, i,
                             chan_code[i*8 +: 8], exp_code[i]);
                end
            end
            checks++;
            if (chan_on != (shutdown ? 8'h00 : 8'hFF)) begin
                failures++;
                $display("FAIL R8 chan_on actual=%0h expected=%0h", chan_on,
                         shutdown ? 8'h00 : 8'hFF);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic void push_word(input int a, input int d);
        for (int k = 2; k >= 0; k--) fq.push_back(bit'((a >> k) & 1));
        for (int k = 7; k >= 0; k--) fq.push_back(bit'((d >> k) & 1));
    endfunction

    task automatic model_preset();
        for (int i = 0; i < 8; i++) exp_code[i] = 'h80;
    endtask

    // Shifts out fq, releases select, then applies the expected write
    task automatic send_frame(input string tag);
        int n;
        int a;
        int d;
        cur_req = tag;
        n = fq.size();
        sel_n = 1'b0;
        tick(4);
        foreach (fq[k]) begin
            sdata = fq[k];
            sclk = 1'b0;
            tick(4);
            sclk = 1'b1;
            tick(4);
        end
        sclk = 1'b0;
        tick(4);
        chk_all("R4");  // nothing changes while select is low
        sel_n = 1'b1;
        hold_cnt = 7;
        a = 0;
        d = 0;
        if (n >= 11) begin
            for (int k = n - 11; k < n - 8; k++) a = a * 2 + int'(fq[k]);
            for (int k = n - 8; k < n; k++) d = d * 2 + int'(fq[k]);
        end
        tick(5);
        if (n >= 11) chk(int'(chan_code[a*8 +: 8]), d, "R4");
        tick(1);
        if (n >= 11) exp_code[a] = d;
        fq.delete();
        tick(6);
    endtask

    initial begin
        model_preset();
        tick(3);
        chk_all("R7");
        preset_n = 1'b1;
        tick(4);
        chk_all("R7");
        chk(int'(chan_on), 'hFF, "R8");

        // R1 R2: first and last channel, bit order
        push_word(0, 'hA5); send_frame("R1");
        chk(int'(chan_code[7:0]), 'hA5, "R1");
        push_word(7, 'h3C); send_frame("R2");
        chk(int'(chan_code[63:56]), 'h3C, "R2");

        // R3: scattered order, only the addressed latch moves
        push_word(5, 'h01); send_frame("R3");
        push_word(2, 'hFE); send_frame("R3");
        push_word(6, 'h00); send_frame("R3");
        push_word(3, 'h7F); send_frame("R3");
        chk_all("R3");

        // R5: ten-bit frame discarded
        push_word(1, 'h55);
        void'(fq.pop_back());
        send_frame("R5");
        chk(int'(chan_code[15:8]), 'h80, "R5");

        // R6: thirteen-bit frame keeps the trailing eleven bits
        fq.push_back(1'b1);
        fq.push_back(1'b1);
        push_word(4, 'hC3);
        send_frame("R6");
        chk(int'(chan_code[39:32]), 'hC3, "R6");

        // R10: sclk toggles outside the select window
        cur_req = "R10";
        for (int k = 0; k < 12; k++) begin
            sdata = k[0];
            sclk = 1'b1; tick(3);
            sclk = 1'b0; tick(3);
        end
        chk_all("R10");
        push_word(1, 'h9A); send_frame("R10");
        chk(int'(chan_code[15:8]), 'h9A, "R10");

        // R8 R9: shutdown holds codes, writes still land
        shutdown = 1'b1;
        cur_req = "R8";
        tick(4);
        chk(int'(chan_on), 0, "R8");
        chk_all("R8");
        push_word(2, 'h44); send_frame("R9");
        chk(int'(chan_code[23:16]), 'h44, "R9");
        shutdown = 1'b0;
        tick(4);
        chk(int'(chan_on), 'hFF, "R8");
        chk(int'(chan_code[23:16]), 'h44, "R9");

        // R7: preset in the middle of a frame
        cur_req = "R7";
        push_word(0, 'h11);
        sel_n = 1'b0;
        tick(4);
        for (int k = 0; k < 5; k++) begin
            sdata = fq[k]; sclk = 1'b0; tick(4);
            sclk = 1'b1; tick(4);
        end
        preset_n = 1'b0;
        model_preset();
        #1;
        chk_all("R7");
        tick(3);
        preset_n = 1'b1;
        for (int k = 5; k < 11; k++) begin
            sdata = fq[k]; sclk = 1'b0; tick(4);
            sclk = 1'b1; tick(4);
        end
        sclk = 1'b0;
        tick(4);
        sel_n = 1'b1;
        fq.delete();
        tick(12);
        chk_all("R7");

        push_word(6, 'hB7); send_frame("R2");
        chk(int'(chan_code[55:48]), 'hB7, "R2");

        tick(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule